// File: doc/BRIEF.md
# Token-Gated Shortcut Route Selector for a Hub Mesh

This block makes the output-port decision for one hub of a two-dimensional mesh of hubs, where a few hubs also own a single-hop wireless shortcut. When a head flit arrives, the block compares two paths. The first is the plain X-then-Y path to the destination hub. The second walks to the shortcut-equipped hub closest to this hub, jumps once, and then walks from the shortcut hub closest to the destination.

The shortcut route is chosen only when it is strictly shorter than the plain path and the buffer-room token of the shortcut hub in question is asserted. Otherwise the flit takes one plain step. The same comparison is made again at the next hub. The chosen port then holds for every flit of the packet until its tail has passed.

Each instance also turns the free-slot count of its own shortcut input buffer into a token bit for its neighbours. The token is registered, so neighbours see it one cycle late. Mesh size, hub position and the set of shortcut hubs are parameters, and all hop lengths are derived from them.

Top module: `shortcut_route_unit`

## Requirements
- R1: While rst_n is low, out_vld and tok_out are 0.
- R2: Each flit accepted with in_vld high yields out_vld high on the next clock edge, with its port on out_port. A cycle without in_vld yields out_vld low on the next edge.
- R3: A head flit whose destination index equals this hub's index (index = y*MESH_X + x) gets port code 0 (local).
- R4: On the plain path, X is resolved before Y. Code 1 means x+1, code 2 means x-1, code 3 means y+1, code 4 means y-1.
- R5: A shortcut is considered only when the shortcut hub nearest this hub differs from the shortcut hub nearest the destination, with ties going to the lower hub index. Its length is d(here, near-here) + 1 + d(near-dest, dest), where d is the Manhattan distance. It is taken only when this length is strictly less than the plain distance; an equal length takes the plain path.
- R6: The shortcut also requires a token. At a hub without a shortcut, the token is tok_in[index of the nearest shortcut hub]. At a shortcut hub, it is tok_in[index of the shortcut hub nearest the destination]. When that bit is 0, the plain-path port is used.
- R7: When the shortcut is taken at a hub without one, the port is the X-then-Y step toward the nearest shortcut hub. At a shortcut hub, the port code is 5 (wireless).
- R8: After a head flit that is not also a tail, later flits get the head's port whatever the tokens and destination do. The flit with in_tail high still uses the held port and then releases it.
- R9: tok_out equals (free_slots > TOK_THRESH) as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A flit is present this cycle |
| in_head | input | 1 | Flit is the head of a packet |
| in_tail | input | 1 | Flit is the tail of a packet |
| in_dst | input | HUB_W | Destination hub index |
| tok_in | input | NHUB | Buffer-room token of each hub's shortcut input |
| free_slots | input | CNT_W | Free entries in this hub's shortcut input buffer |
| out_vld | output | 1 | Decision valid |
| out_port | output | 3 | Chosen port code |
| tok_out | output | 1 | Registered token for this hub's shortcut input |

## Verification
The hardest case to reach is a packet whose head picked the shortcut and whose token then drops while body and tail flits are still arriving. The bench sends the head with tokens raised, clears every token on the next flit, and expects the held port through the tail. It then checks that a fresh head falls back to the plain step. Equal-length ties between the two paths are covered by choosing destinations whose computed lengths match exactly, and three instances at different hubs give all four step directions and the wireless code.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_NORTH = 3'd4,
    PORT_AIR   = 3'd5
  } port_e;

  function automatic int abs_diff(input int a, input int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic int hop_dist(input int ax, input int ay,
                                  input int bx, input int by);
    return abs_diff(ax, bx) + abs_diff(ay, by);
  endfunction

endpackage

// File: rtl/srt_token_gen.sv
module srt_token_gen #(
  parameter int CNT_W      = 4,
  parameter int TOK_THRESH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] free_slots,
  output logic             tok_out
);

  logic tok_q, tok_d;

  always_comb begin
    tok_d = (int'(free_slots) > TOK_THRESH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= 1'b0;
    else        tok_q <= tok_d;
  end

  assign tok_out = tok_q;

  // R9: token follows the free-slot comparison one cycle late
  a_r9_token_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tok_out == (int'($past(free_slots)) > TOK_THRESH)));

endmodule

// File: rtl/srt_route_eval.sv
module srt_route_eval
  import srt_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int HUB_ID = 0,
  parameter logic [MESH_X*MESH_Y-1:0] WI_MASK = '0,
  localparam int NHUB  = MESH_X * MESH_Y,
  localparam int HUB_W = (NHUB > 1) ? $clog2(NHUB) : 1
) (
  input  logic [HUB_W-1:0] in_dst,
  input  logic [NHUB-1:0]  tok_in,
  output port_e            sel_port,
  output logic [HUB_W-1:0] dst_wi,
  output logic             take_sc
);

  localparam int CUR_X  = HUB_ID % MESH_X;
  localparam int CUR_Y  = HUB_ID / MESH_X;
  localparam bit IS_WI  = WI_MASK[HUB_ID];
  localparam bit HAS_WI = (WI_MASK != '0);

  function automatic int nearest_hub(input int px, input int py);
    int best, bestd, d;
    best  = 0;
    bestd = NHUB * 4;
    for (int h = 0; h < NHUB; h++) begin
      if (WI_MASK[h]) begin
        d = hop_dist(px, py, h % MESH_X, h / MESH_X);
        if (d < bestd) begin
          bestd = d;
          best  = h;
        end
      end
    end
    return best;
  endfunction

  localparam int SRC_WI = nearest_hub(CUR_X, CUR_Y);
  localparam int SRC_X  = SRC_WI % MESH_X;
  localparam int SRC_Y  = SRC_WI / MESH_X;
  localparam int SRC_D  = hop_dist(CUR_X, CUR_Y, SRC_X, SRC_Y);

  int   dx, dy, dw, wired_len, sc_len, tx, ty;
  logic tok_sel;

  always_comb begin
    dx        = int'(in_dst) % MESH_X;
    dy        = int'(in_dst) / MESH_X;
    dw        = nearest_hub(dx, dy);
    dst_wi    = HUB_W'(dw);
    wired_len = hop_dist(CUR_X, CUR_Y, dx, dy);
    sc_len    = SRC_D + 1 + hop_dist(dw % MESH_X, dw / MESH_X, dx, dy);
    tok_sel   = IS_WI ? tok_in[dst_wi] : tok_in[SRC_WI];
    take_sc   = HAS_WI && (dw != SRC_WI) && (sc_len < wired_len) && tok_sel;
    tx        = take_sc ? SRC_X : dx;
    ty        = take_sc ? SRC_Y : dy;
    if (take_sc && IS_WI)  sel_port = PORT_AIR;
    else if (tx > CUR_X)   sel_port = PORT_EAST;
    else if (tx < CUR_X)   sel_port = PORT_WEST;
    else if (ty > CUR_Y)   sel_port = PORT_SOUTH;
    else if (ty < CUR_Y)   sel_port = PORT_NORTH;
    else                   sel_port = PORT_LOCAL;
  end

endmodule

// File: rtl/srt_path_lock.sv
module srt_path_lock
  import srt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_vld,
  input  logic  in_head,
  input  logic  in_tail,
  input  port_e sel_port,
  output logic  out_vld,
  output port_e out_port
);

  logic  locked_q, locked_d;
  port_e hold_q, hold_d;
  logic  vld_q, vld_d;
  port_e port_q, port_d;
  port_e use_port;

  always_comb begin
    use_port = (in_head || !locked_q) ? sel_port : hold_q;
    locked_d = locked_q;
    hold_d   = hold_q;
    if (in_vld) begin
      if (in_head && !in_tail) begin
        locked_d = 1'b1;
        hold_d   = sel_port;
      end else if (in_tail) begin
        locked_d = 1'b0;
      end
    end
    vld_d  = in_vld;
    port_d = in_vld ? use_port : port_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      hold_q   <= PORT_LOCAL;
      vld_q    <= 1'b0;
      port_q   <= PORT_LOCAL;
    end else begin
      locked_q <= locked_d;
      hold_q   <= hold_d;
      vld_q    <= vld_d;
      port_q   <= port_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_port = port_q;

  // R8: a non-head flit inside a held packet keeps the held port
  a_r8_hold_port: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_head && locked_q) |=> (out_port == $past(hold_q)));

endmodule

// File: rtl/shortcut_route_unit.sv
module shortcut_route_unit
  import srt_pkg::*;
#(
  parameter int MESH_X     = 4,
  parameter int MESH_Y     = 4,
  parameter int HUB_ID     = 0,
  parameter logic [MESH_X*MESH_Y-1:0] WI_MASK = 16'h4001,
  parameter int CNT_W      = 4,
  parameter int TOK_THRESH = 4,
  localparam int NHUB  = MESH_X * MESH_Y,
  localparam int HUB_W = (NHUB > 1) ? $clog2(NHUB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_head,
  input  logic             in_tail,
  input  logic [HUB_W-1:0] in_dst,
  input  logic [NHUB-1:0]  tok_in,
  input  logic [CNT_W-1:0] free_slots,
  output logic             out_vld,
  output logic [2:0]       out_port,
  output logic             tok_out
);

  port_e            sel_port, lock_port;
  logic [HUB_W-1:0] dst_wi;
  logic             take_sc;

  srt_route_eval #(
    .MESH_X (MESH_X),
    .MESH_Y (MESH_Y),
    .HUB_ID (HUB_ID),
    .WI_MASK(WI_MASK)
  ) u_eval (
    .in_dst  (in_dst),
    .tok_in  (tok_in),
    .sel_port(sel_port),
    .dst_wi  (dst_wi),
    .take_sc (take_sc)
  );

  srt_path_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_head (in_head),
    .in_tail (in_tail),
    .sel_port(sel_port),
    .out_vld (out_vld),
    .out_port(lock_port)
  );

  srt_token_gen #(
    .CNT_W     (CNT_W),
    .TOK_THRESH(TOK_THRESH)
  ) u_tok (
    .clk       (clk),
    .rst_n     (rst_n),
    .free_slots(free_slots),
    .tok_out   (tok_out)
  );

  assign out_port = lock_port;

  // R2: every accepted flit produces a decision one edge later
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R3: a head for this hub leaves on the local port
  a_r3_local_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_head && (int'(in_dst) == HUB_ID)) |=> (out_port == PORT_LOCAL));

  // R6: a wireless decision on a head needs the destination-side token
  a_r6_air_token: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_head && take_sc && (sel_port == PORT_AIR))
      |=> ((out_port == PORT_AIR) && $past(tok_in[dst_wi])));

endmodule

// File: tb/tb_shortcut_route_unit.sv
module tb_shortcut_route_unit;
  import srt_pkg::*;

  typedef struct {
    logic [2:0] port;
    string      what;
  } exp_t;

  logic       clk, rst_n;
  logic       in_vld, in_head, in_tail;
  logic [3:0] in_dst;
  logic [15:0] tok_in;
  logic [3:0] free_slots;
  logic       va, vb, vc, ta, tb_t, tc;
  logic [2:0] pa, pb, pc;

  int checks = 0;
  int fails  = 0;
  exp_t qa[$], qb[$], qc[$];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Hub 4 (0,1): no shortcut; nearest shortcut hub is 0
  shortcut_route_unit #(.HUB_ID(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_head(in_head),
    .in_tail(in_tail), .in_dst(in_dst), .tok_in(tok_in),
    .free_slots(free_slots), .out_vld(va), .out_port(pa), .tok_out(ta));

  // Hub 0 (0,0): owns a shortcut
  shortcut_route_unit #(.HUB_ID(0)) dut_b (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_head(in_head),
    .in_tail(in_tail), .in_dst(in_dst), .tok_in(tok_in),
    .free_slots(free_slots), .out_vld(vb), .out_port(pb), .tok_out(tb_t));

  // Hub 7 (3,1): no shortcut; nearest shortcut hub is 14
  shortcut_route_unit #(.HUB_ID(7)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_head(in_head),
    .in_tail(in_tail), .in_dst(in_dst), .tok_in(tok_in),
    .free_slots(free_slots), .out_vld(vc), .out_port(pc), .tok_out(tc));

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic mon(input string nm, input logic v, input logic [2:0] p, ref exp_t q[$]);
    exp_t e;
    if (v) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 %s: unexpected decision port %0d expected none", nm, p);
      end else begin
        e = q.pop_front();
        check({nm, " ", e.what}, {5'd0, p}, {5'd0, e.port});
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      mon("hub4", va, pa, qa);
      mon("hub0", vb, pb, qb);
      mon("hub7", vc, pc, qc);
    end
  end

  task automatic send(input logic [3:0] dst, input logic hd, input logic tl,
                      input logic [15:0] tok, input port_e ea, input port_e eb,
                      input port_e ec, input string what);
    @(negedge clk);
    in_vld = 1'b1; in_head = hd; in_tail = tl; in_dst = dst; tok_in = tok;
    qa.push_back('{ea, what});
    qb.push_back('{eb, what});
    qc.push_back('{ec, what});
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0; in_head = 1'b0; in_tail = 1'b0;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_head = 1'b0; in_tail = 1'b0;
    in_dst = '0; tok_in = '0; free_slots = 4'd0;
    repeat (3) @(negedge clk);
    check("R1 out_vld in reset", {7'd0, va | vb | vc}, 8'd0);
    check("R1 tok_out in reset", {7'd0, ta | tb_t | tc}, 8'd0);
    rst_n = 1'b1;

    // R3 local exit, R4 plain steps
    send(4'd4,  1, 1, 16'hFFFF, PORT_LOCAL, PORT_SOUTH, PORT_WEST,  "R3/R4 dst4");
    send(4'd0,  1, 1, 16'hFFFF, PORT_NORTH, PORT_LOCAL, PORT_WEST,  "R3/R5 dst0 tie");
    send(4'd12, 1, 1, 16'hFFFF, PORT_SOUTH, PORT_SOUTH, PORT_WEST,  "R5 dst12 equal length");
    // R7 detour toward nearest shortcut hub, wireless port at a shortcut hub
    send(4'd15, 1, 1, 16'hFFFF, PORT_NORTH, PORT_AIR,   PORT_SOUTH, "R7 dst15 shortcut");
    // R6 tokens off: plain path
    send(4'd15, 1, 1, 16'h0000, PORT_EAST,  PORT_EAST,  PORT_SOUTH, "R6 dst15 no token");
    // R6: only the relevant token matters
    send(4'd15, 1, 1, 16'h0001, PORT_NORTH, PORT_EAST,  PORT_SOUTH, "R6 dst15 tok0 only");
    send(4'd15, 1, 1, 16'h4000, PORT_EAST,  PORT_AIR,   PORT_SOUTH, "R6 dst15 tok14 only");
    send(4'd11, 1, 1, 16'hFFFF, PORT_EAST,  PORT_AIR,   PORT_SOUTH, "R5 dst11");
    send(4'd7,  1, 1, 16'hFFFF, PORT_EAST,  PORT_EAST,  PORT_LOCAL, "R5 dst7 equal");
    send(4'd3,  1, 1, 16'hFFFF, PORT_EAST,  PORT_EAST,  PORT_NORTH, "R5 dst3 same shortcut hub");
    idle();
    idle();
    check("R2 out_vld low after idle", {7'd0, va | vb | vc}, 8'd0);

    // R8 held port across body and tail while tokens drop
    send(4'd15, 1, 0, 16'hFFFF, PORT_NORTH, PORT_AIR,   PORT_SOUTH, "R8 head");
    send(4'd3,  0, 0, 16'h0000, PORT_NORTH, PORT_AIR,   PORT_SOUTH, "R8 body");
    send(4'd3,  0, 1, 16'h0000, PORT_NORTH, PORT_AIR,   PORT_SOUTH, "R8 tail");
    send(4'd15, 1, 1, 16'h0000, PORT_EAST,  PORT_EAST,  PORT_SOUTH, "R8 released");
    idle();
    idle();

    // R9 token generation with threshold 4
    @(negedge clk);
    free_slots = 4'd5;
    #1 check("R9 token not yet updated", {7'd0, ta}, 8'd0);
    @(negedge clk);
    check("R9 token on above threshold", {7'd0, ta}, 8'd1);
    free_slots = 4'd4;
    @(negedge clk);
    check("R9 token off at threshold", {7'd0, ta}, 8'd0);
    free_slots = 4'd15;
    @(negedge clk);
    check("R9 token on at max", {7'd0, tb_t}, 8'd1);

    idle();
    check("R2 all decisions seen", {5'd0, 3'(qa.size() + qb.size() + qc.size())}, 8'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule